// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit collects events from a serial bus controller's engine and reports them to software. Each event arrives as a one-cycle pulse and is held in a 16-bit sticky status register. Software clears held bits by writing ones to them. An enable register selects which held events raise the single interrupt line. That line is registered.

A second, older way to service the events is also provided. A vector register returns a small code naming the most urgent pending event among the five basic ones. Reading that register retires the event it named. Both ways act on the same status bits, so they always agree. A level bus-busy input appears in the status word without being held. Software cannot clear it, and no enable is attached to it.

Access goes through a simple select/read/write port. Read data is combinational on the selected register.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, status, enable and vector read 0 and `irq` is low, provided `bus_busy` is low.
- R2: A one-cycle pulse on `evt_pulse` bit k sets held status bit k from the next clock edge. The held positions are 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 8 address zero, 9 addressed as slave, 10 transmit underflow, 11 receive overrun, 13 receive drain and 14 transmit drain.
- R3: A write to the status register (`reg_sel`=0) clears every held bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: When an event pulse and a clearing write (or a vector read) hit the same bit in the same cycle, the bit remains set.
- R5: Status bit 12 follows `bus_busy` in the same cycle, and writes cannot clear it.
- R6: The enable register (`reg_sel`=1) stores only bits 0-4, 13 and 14. Every other enable bit reads 0. Status bits 5-7 and 15 always read 0, even when they are pulsed.
- R7: `irq` is the OR over all bits of (status AND enable), taken through one register. It therefore changes one clock edge after the status or enable change that causes it.
- R8: The vector register (`reg_sel`=2) returns 0 when none of status bits 0-4 is set. Otherwise it returns i+1, where i is the lowest set bit among bits 0-4. The codes are 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready and 5 transmit ready.
- R9: Reading the vector with `reg_rd` high clears the status bit it reported at that clock edge. Reading it with `reg_rd` low, or reading it when it is 0, clears nothing.
- R10: Select value 3 reads 0. Writes with `reg_sel` 2 or 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 16 | One-cycle event pulses, one per status position |
| bus_busy | input | 1 | Live bus-busy level |
| reg_sel | input | 2 | Register select: 0 status, 1 enable, 2 vector, 3 none |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (only a vector read has a side effect) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Registered interrupt request |

## Verification
Held status bits, enable bits and vector clears take effect at the first clock edge after the stimulus. `irq` follows one edge later. Bus busy and read data are visible in the same cycle. The bench drives inputs on the falling edge and reads `reg_rdata` one nanosecond later. For an interrupt check, it first confirms that `irq` is still low one falling edge after the event, then confirms it is high one falling edge after that. This exposes both a missing register stage and an extra one. Each vector read is sampled before the edge that retires the event, and status is re-read afterwards.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_pulse,
  input  logic          bus_busy,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam logic [DW-1:0] HELD_M = DW'(16'h6F1F);
  localparam logic [DW-1:0] EN_M   = DW'(16'h601F);
  localparam int BUSY_POS = 12;
  localparam int VEC_N    = 5;
  localparam int VW       = $clog2(VEC_N + 1);

  logic [DW-1:0] stat_q, en_q, stat_vis, wclr, vclr, stat_d;
  logic [VW-1:0] vec_code;
  logic          irq_q;

  assign stat_vis = stat_q | (DW'(bus_busy) << BUSY_POS);

  always_comb begin
    vec_code = '0;
    for (int i = VEC_N - 1; i >= 0; i--)
      if (stat_q[i]) vec_code = VW'(i + 1);
  end

  assign wclr = (reg_wr && reg_sel == 2'd0) ? reg_wdata : '0;
  assign vclr = (reg_rd && reg_sel == 2'd2 && vec_code != '0) ?
                (DW'(1) << (vec_code - VW'(1))) : '0;
  assign stat_d = ((stat_q & ~(wclr | vclr)) | evt_pulse) & HELD_M;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (reg_wr && reg_sel == 2'd1) en_q <= reg_wdata & EN_M;
      irq_q  <= |(stat_vis & en_q);
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = stat_vis;
      2'd1:    reg_rdata = en_q;
      2'd2:    reg_rdata = DW'(vec_code);
      default: reg_rdata = '0;
    endcase
  end

  assign irq = irq_q;
endmodule

module irq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] evt_pulse,
  input logic [1:0]  reg_sel,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [15:0] reg_wdata,
  input logic [15:0] stat_q,
  input logic [15:0] en_q,
  input logic        bus_busy,
  input logic [2:0]  vec_code,
  input logic        irq
);
  localparam logic [15:0] HELD_M = 16'h6F1F;
  logic [15:0] vbit;
  assign vbit = (vec_code == 3'd0) ? 16'h0 : (16'h1 << (vec_code - 3'd1));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0) |=>
      ((stat_q & $past(reg_wdata) & ~$past(evt_pulse) & HELD_M) == 16'h0));

  // R4
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(evt_pulse & HELD_M)) == $past(evt_pulse & HELD_M)));

  // R7
  irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|((stat_q | (16'(bus_busy) << 12)) & en_q))));

  // R8
  vec_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_code != 3'd0) |-> (vec_code <= 3'd5 && (stat_q & vbit) != 16'h0
                            && (stat_q & (vbit - 16'h1)) == 16'h0));

  // R9
  vec_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == 2'd2 && vec_code != 3'd0 && (evt_pulse & vbit) == 16'h0)
      |=> ((stat_q & $past(vbit)) == 16'h0));
endmodule

bind irq_status_unit irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_sel(reg_sel),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
  .stat_q(stat_q), .en_q(en_q), .bus_busy(bus_busy),
  .vec_code(vec_code), .irq(irq)
);

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_pulse = '0;
  logic        bus_busy = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_busy(bus_busy),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [15:0] m);
    evt_pulse = m; @(negedge clk); evt_pulse = '0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1; @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic strobe, output logic [15:0] d);
    reg_sel = s; reg_rd = strobe; #1 d = reg_rdata; @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(2'd0, 1'b0, d); chk("R1 status", d, 16'h0);
    rd(2'd1, 1'b0, d); chk("R1 enable", d, 16'h0);
    rd(2'd2, 1'b1, d); chk("R1 vector", d, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_set_unused;
    logic [15:0] d;
    pulse(16'h6F1F); rd(2'd0, 1'b0, d); chk("R2 held bits", d, 16'h6F1F);
    pulse(16'h80E0); rd(2'd0, 1'b0, d); chk("R6 unused status", d, 16'h6F1F);
    wr(2'd0, 16'hFFFF); rd(2'd0, 1'b0, d); chk("R3 clear all", d, 16'h0);
  endtask

  task automatic t_w1c;
    logic [15:0] d;
    pulse(16'h0003);
    wr(2'd0, 16'h0001); rd(2'd0, 1'b0, d); chk("R3 partial clear", d, 16'h0002);
    wr(2'd0, 16'h0000); rd(2'd0, 1'b0, d); chk("R3 zero write", d, 16'h0002);
    wr(2'd0, 16'hFFFF);
  endtask

  task automatic t_race;
    logic [15:0] d;
    evt_pulse = 16'h0004; wr(2'd0, 16'h0004); evt_pulse = '0;
    rd(2'd0, 1'b0, d); chk("R4 event beats write", d, 16'h0004);
    evt_pulse = 16'h0004; rd(2'd2, 1'b1, d); evt_pulse = '0;
    chk("R4 vector code", d, 16'h0003);
    rd(2'd0, 1'b0, d); chk("R4 event beats vector read", d, 16'h0004);
    wr(2'd0, 16'hFFFF);
  endtask

  task automatic t_busy;
    logic [15:0] d;
    bus_busy = 1'b1; rd(2'd0, 1'b0, d); chk("R5 busy live", d, 16'h1000);
    wr(2'd0, 16'hFFFF); rd(2'd0, 1'b0, d); chk("R5 busy uncleared", d, 16'h1000);
    bus_busy = 1'b0; rd(2'd0, 1'b0, d); chk("R5 busy drop", d, 16'h0);
  endtask

  task automatic t_enable;
    logic [15:0] d;
    wr(2'd1, 16'hFFFF); rd(2'd1, 1'b0, d); chk("R6 enable mask", d, 16'h601F);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_irq;
    wr(2'd1, 16'h0002);
    pulse(16'h0001); @(negedge clk);
    chk("R7 masked event", {15'h0, irq}, 16'h0);
    pulse(16'h0002);
    chk("R7 latency low", {15'h0, irq}, 16'h0);
    @(negedge clk); chk("R7 raised", {15'h0, irq}, 16'h1);
    wr(2'd0, 16'h0002);
    chk("R7 still set one edge", {15'h0, irq}, 16'h1);
    @(negedge clk); chk("R7 dropped", {15'h0, irq}, 16'h0);
    wr(2'd0, 16'hFFFF); wr(2'd1, 16'hFFFF);
    bus_busy = 1'b1; @(negedge clk); @(negedge clk);
    chk("R7 busy no irq", {15'h0, irq}, 16'h0);
    bus_busy = 1'b0; wr(2'd1, 16'h0000);
  endtask

  task automatic t_vector;
    logic [15:0] d;
    pulse(16'h001F);
    for (int k = 1; k <= 5; k++) begin
      rd(2'd2, 1'b1, d); chk("R8 priority code", d, 16'(k));
    end
    rd(2'd2, 1'b1, d); chk("R8 empty", d, 16'h0);
    rd(2'd0, 1'b0, d); chk("R9 all retired", d, 16'h0);
    pulse(16'h0010);
    rd(2'd2, 1'b0, d); chk("R8 transmit code", d, 16'h0005);
    rd(2'd0, 1'b0, d); chk("R9 peek keeps", d, 16'h0010);
    pulse(16'h2008);
    rd(2'd2, 1'b1, d); chk("R8 receive code", d, 16'h0004);
    rd(2'd0, 1'b0, d); chk("R9 one retired", d, 16'h2010);
    wr(2'd0, 16'hFFFF);
  endtask

  task automatic t_select;
    logic [15:0] d;
    wr(2'd1, 16'h0005); pulse(16'h0100);
    wr(2'd2, 16'hFFFF); wr(2'd3, 16'hFFFF);
    rd(2'd1, 1'b0, d); chk("R10 enable kept", d, 16'h0005);
    rd(2'd0, 1'b0, d); chk("R10 status kept", d, 16'h0100);
    rd(2'd3, 1'b1, d); chk("R10 sel3 zero", d, 16'h0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_unused();
    t_w1c();
    t_race();
    t_busy();
    t_enable();
    t_irq();
    t_vector();
    t_select();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule